// File: doc/BRIEF.md
# Game Datapath Register File with Display Taps

This block is the storage element of a small 16-bit game datapath. It holds sixteen 16-bit words selected by 4-bit addresses. The control sequencer reads two operands at once through two independent combinational read ports. Results return through a single synchronous write port made of an address, a data word and a write enable.

Several addresses have fixed roles in the game. Address 0x0 holds the first player's score and 0x1 the second player's score. Addresses 0x2 and 0x3 hold the players' press counts. Address 0x7 holds the collectible counter, 0x8 holds the seconds remaining, and 0x9 through 0xF are scratch words. Four of these words are also copied without pause onto dedicated outputs: both scores, the timer and the counter. The display logic can show them without using a read port, and the shown counter always equals the stored one.

Reset is asynchronous and active low, and the clock must release it synchronously. Reset clears every word to zero.

Top module: `game_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every word reads 0 through both read ports and on all four display outputs, until the first write.
- R2: When `wr_en` is 1 at a rising clock edge, the word at `wr_addr` takes the value of `wr_data`. The new value can be read from the next cycle on.
- R3: When `wr_en` is 0 at a rising clock edge, no word changes, whatever `wr_addr` and `wr_data` carry.
- R4: A write changes only the addressed word. The other fifteen words keep their values.
- R5: `rd_data_a` shows the word at `rd_addr_a`, and `rd_data_b` shows the word at `rd_addr_b`. Both are combinational and independent, so both ports may select the same address or different ones.
- R6: If a read port selects the address being written in the same cycle, it shows the old value before the edge and the new value after it.
- R7: `disp_score_p1` always equals word 0x0, `disp_score_p2` always equals word 0x1, and `disp_timer` always equals word 0x8.
- R8: `disp_counter` always equals word 0x7, the collectible counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 4 | Address of the word to write |
| wr_data | input | 16 | Value to write |
| rd_addr_a | input | 4 | Address for read port A |
| rd_data_a | output | 16 | Combinational data of read port A |
| rd_addr_b | input | 4 | Address for read port B |
| rd_data_b | output | 16 | Combinational data of read port B |
| disp_score_p1 | output | 16 | Always shows word 0x0 (player 1 score) |
| disp_score_p2 | output | 16 | Always shows word 0x1 (player 2 score) |
| disp_timer | output | 16 | Always shows word 0x8 (seconds remaining) |
| disp_counter | output | 16 | Always shows word 0x7 (collectible counter) |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` hold stable values with no unknown bits around each rising edge while reset is released, and that reset is released away from an edge. The bench drives every input on the falling edge and sets `wr_en` to a known value on every cycle after reset. It samples outputs one nanosecond after an edge, so no sampled value sits in the window the assertions rely on. The sweeps visit every address on both read ports and use data patterns that differ in every bit position. As a result, a stuck, swapped or aliased word shows up as a value mismatch.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Role addresses of the game datapath storage map
  localparam int unsigned ROLE_SCORE_P1  = 4'h0;
  localparam int unsigned ROLE_SCORE_P2  = 4'h1;
  localparam int unsigned ROLE_PRESS_P1  = 4'h2;
  localparam int unsigned ROLE_PRESS_P2  = 4'h3;
  localparam int unsigned ROLE_COUNTER   = 4'h7;
  localparam int unsigned ROLE_TIMER     = 4'h8;
  localparam int unsigned ROLE_SCRATCH_LO = 4'h9;

  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_ADDR_W = 4;

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:0]  word_we
);

  always_comb begin
    word_we = '0;
    if (wr_en) begin
      word_we[wr_addr] = 1'b1;
    end
  end

  // R4: at most one word may be enabled in any cycle
  assert_single_word_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we));

  // R3: no enable without a request
  assert_no_enable_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (word_we == '0));

endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] word_q
);

  logic [DATA_W-1:0] word_d;

  // Next-state: hold unless the clock enable is raised
  always_comb begin
    word_d = word_q;
    if (load_en) begin
      word_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  // R4/R3: a word without its enable keeps its value
  assert_word_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(word_q));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] words_i,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data
);

  always_comb begin
    rd_data = words_i[rd_addr];
  end

endmodule

// File: rtl/game_regfile.sv
module game_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W        = DEF_DATA_W,
  parameter int unsigned ADDR_W        = DEF_ADDR_W,
  parameter int unsigned TAP_SCORE1    = ROLE_SCORE_P1,
  parameter int unsigned TAP_SCORE2    = ROLE_SCORE_P2,
  parameter int unsigned TAP_TIMER     = ROLE_TIMER,
  parameter int unsigned TAP_COUNTER   = ROLE_COUNTER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] disp_score_p1,
  output logic [DATA_W-1:0] disp_score_p2,
  output logic [DATA_W-1:0] disp_timer,
  output logic [DATA_W-1:0] disp_counter
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_SCORE1  = ADDR_W'(TAP_SCORE1);
  localparam logic [ADDR_W-1:0] A_SCORE2  = ADDR_W'(TAP_SCORE2);
  localparam logic [ADDR_W-1:0] A_TIMER   = ADDR_W'(TAP_TIMER);
  localparam logic [ADDR_W-1:0] A_COUNTER = ADDR_W'(TAP_COUNTER);

  logic [DEPTH-1:0]             word_we;
  logic [DEPTH-1:0][DATA_W-1:0] words;

  rf_write_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .word_we (word_we)
  );

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    rf_word #(.DATA_W(DATA_W)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (word_we[gi]),
      .load_data (wr_data),
      .word_q    (words[gi])
    );
  end

  rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_a (
    .words_i (words),
    .rd_addr (rd_addr_a),
    .rd_data (rd_data_a)
  );

  rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_b (
    .words_i (words),
    .rd_addr (rd_addr_b),
    .rd_data (rd_data_b)
  );

  // Display taps: straight wires from fixed storage words
  always_comb begin
    disp_score_p1 = words[A_SCORE1];
    disp_score_p2 = words[A_SCORE2];
    disp_timer    = words[A_TIMER];
    disp_counter  = words[A_COUNTER];
  end

  // R2: a requested write lands in the addressed word
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (words[$past(wr_addr)] == $past(wr_data)));

  // R3: an idle cycle leaves all storage untouched
  assert_idle_keeps_storage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words));

  // R7: score and timer displays follow writes to their words
  assert_score1_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SCORE1) |=> (disp_score_p1 == $past(wr_data)));
  assert_score2_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SCORE2) |=> (disp_score_p2 == $past(wr_data)));
  assert_timer_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TIMER) |=> (disp_timer == $past(wr_data)));
  assert_timer_tap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_TIMER) |=> $stable(disp_timer));

  // R8: counter display follows its word and never drifts
  assert_counter_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_COUNTER) |=> (disp_counter == $past(wr_data)));
  assert_counter_tap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_COUNTER) |=> $stable(disp_counter));

  // R5: read port B follows the last value written to its address
  assert_port_b_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_addr_b == wr_addr) |=> (rd_addr_b != $past(rd_addr_b)) ||
                                        (rd_data_b == $past(wr_data)));

endmodule

// File: tb/game_regfile_tb_top.sv
module game_regfile_tb_top;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int N  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr_a;
  logic [DW-1:0] rd_data_a;
  logic [AW-1:0] rd_addr_b;
  logic [DW-1:0] rd_data_b;
  logic [DW-1:0] disp_score_p1;
  logic [DW-1:0] disp_score_p2;
  logic [DW-1:0] disp_timer;
  logic [DW-1:0] disp_counter;

  logic [DW-1:0] model [N];
  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  game_regfile dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr_a     (rd_addr_a),
    .rd_data_a     (rd_data_a),
    .rd_addr_b     (rd_addr_b),
    .rd_data_b     (rd_data_b),
    .disp_score_p1 (disp_score_p1),
    .disp_score_p2 (disp_score_p2),
    .disp_timer    (disp_timer),
    .disp_counter  (disp_counter)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    if (en) model[a] = d;
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_addr_a = AW'(i);
      rd_addr_b = AW'(N - 1 - i);
      #1;
      check({req, " port A"}, rd_data_a, model[i]);
      check({req, " port B"}, rd_data_b, model[N - 1 - i]);
    end
  endtask

  task automatic check_taps();
    #1;
    check("R7 score1 tap", disp_score_p1, model[0]);
    check("R7 score2 tap", disp_score_p2, model[1]);
    check("R7 timer tap", disp_timer, model[8]);
    check("R8 counter tap", disp_counter, model[7]);
  endtask

  function automatic logic [DW-1:0] pat1(input int i);
    return DW'(16'hA5C3 ^ (i * 16'h1357) ^ (i << 9));
  endfunction

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: during reset
    check_all("R1 in reset");
    check_taps();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: after release
    check_all("R1 after release");
    check_taps();

    // R2, R5: write a distinct pattern to every address, read back crosswise
    for (int i = 0; i < N; i++) write_word(AW'(i), pat1(i), 1'b1);
    check_all("R2 R5 pattern1");
    check_taps();

    // R3: wr_en low, data sweeps every address
    for (int i = 0; i < N; i++) begin
      write_word(AW'(i), ~pat1(i), 1'b0);
      #1;
      rd_addr_a = AW'(i);
      #1;
      check("R3 ignored write", rd_data_a, model[i]);
    end
    check_taps();

    // R4: walking-one data into single words; others unchanged
    for (int i = 0; i < N; i++) begin
      write_word(AW'(i), DW'(1) << i, 1'b1);
      check_all("R4 single write");
      check_taps();
    end

    // R5: both ports on the same address
    for (int i = 0; i < N; i++) begin
      rd_addr_a = AW'(i); rd_addr_b = AW'(i);
      #1;
      check("R5 same addr A", rd_data_a, model[i]);
      check("R5 same addr B", rd_data_b, model[i]);
    end

    // R6: read during write shows old then new
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = DW'(16'h0F0F + i * 16'h0101);
      rd_addr_a = AW'(i); rd_addr_b = AW'(i);
      #1;
      check("R6 old before edge", rd_data_a, model[i]);
      @(posedge clk); #1;
      model[i] = DW'(16'h0F0F + i * 16'h0101);
      wr_en = 1'b0;
      check("R6 new after edge A", rd_data_a, model[i]);
      check("R6 new after edge B", rd_data_b, model[i]);
    end
    check_taps();

    // R8, R7: repeated counter/timer updates track the displays
    for (int k = 0; k < 40; k++) begin
      write_word(AW'(7), DW'(k * 3), 1'b1);
      write_word(AW'(8), DW'(30 - k), 1'b1);
      check_taps();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule